// File: doc/BRIEF.md
# Timer Forced-Event Command Unit

This block lets software force the events of a 16-bit advanced timer by writing ones into a command register. Each bit of the written word stands for one event: output brake, trigger, commutation, a compare/capture event on one of four channels, or an update. A forced event sets its status flag, drives the interrupt line when that flag's interrupt enable is set, and sends a one-cycle DMA request when that event's DMA enable is set. Some events also act on timer state. A brake drops the main output enable. A commutation loads the preloaded channel settings. A capture on an input channel latches the live counter. An update reloads the counter and restarts the prescaler.

The unit contains a simple prescaled counter with up, down and centre-aligned counting, four capture registers, the status register and the main output enable. Software clears status flags by writing zeros through a separate status port. Command bits have no storage. They read back as zero, and each one acts in the clock cycle after the write strobe.

Top module: `tmr_evgen`

## Requirements
- R1: After reset, the counter, the capture registers, the status word, the applied channel configuration, the main output enable and all DMA requests are zero.
- R2: `cmd_rdata` always reads zero. Bits 15:8 of a command write, and any bit written as zero, change no state or output.
- R3: Command bit 7 (brake) clears `moe` and sets status bit 7 in the next cycle. It takes priority over a simultaneous `moe_set`.
- R4: Command bit 6 (trigger) sets status bit 6 in the next cycle.
- R5: Command bit 5 (commutation) sets status bit 5. It copies `pre_cfg` into `act_cfg` only when `ccpc` is 1, and otherwise leaves `act_cfg` unchanged.
- R6: Command bit i+1 (channel i+1, i=0..3) on a channel whose `ch_in[i]` is 0 sets status bit i+1 and leaves that channel's capture register unchanged.
- R7: The same command on a channel whose `ch_in[i]` is 1 copies the counter value present at the write edge into capture slot i (`ccr[16i+15:16i]`) and sets status bit i+1. If status bit i+1 was already set, it also sets the overcapture status bit 9+i.
- R8: Command bit 0 (update) sets status bit 0. It loads the counter with `arr` when counting down in edge mode and with zero otherwise. It clears the prescaler count and keeps `psc`, so the next counter step comes psc+1 enabled cycles later.
- R9: A status write with `sts_we` clears each flag at bits 7:0 and 12:9 whose written bit is 0 and keeps each flag whose written bit is 1. A hardware set in the same cycle wins over the clear.
- R10: `irq` is high while any status bit 7:0 is set together with the same bit of `irq_en`.
- R11: `dma_req[k]` is high for exactly the one cycle after a command write with bit k set, and only if `dma_en[k]` is set.
- R12: When `cnt_en` is set, the counter steps once every psc+1 cycles. In edge mode it counts up and wraps from `arr` to 0, or counts down and wraps from 0 to `arr`. In centre mode it counts up to `arr` and then back down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command write data |
| cmd_rdata | output | 16 | Command register read value (zero) |
| sts_we | input | 1 | Status write strobe (write zero to clear) |
| sts_wdata | input | 16 | Status write data |
| sts_rdata | output | 16 | Status flags: 7:0 events, 12:9 overcapture |
| irq_en | input | 8 | Interrupt enable per event flag |
| dma_en | input | 8 | DMA enable per event |
| cnt_en | input | 1 | Counter enable |
| dir_down | input | 1 | Edge-mode count direction, 1 = down |
| center | input | 1 | Centre-aligned counting |
| arr | input | 16 | Auto-reload value |
| psc | input | 16 | Prescaler divide factor minus one |
| ch_in | input | 4 | Channel configured as input, one bit per channel |
| ccpc | input | 1 | Preload control for commutation |
| pre_cfg | input | 9 | Preloaded settings, 3 bits per channel 1..3 |
| moe_set | input | 1 | Sets the main output enable |
| cnt | output | 16 | Live counter |
| ccr | output | 64 | Capture registers, channel 1 in bits 15:0 |
| act_cfg | output | 9 | Applied channel settings |
| moe | output | 1 | Main output enable |
| irq | output | 1 | Interrupt request |
| dma_req | output | 8 | DMA request pulses per event |

## Verification
The bound assertions check every cycle that a brake drops the output enable, that overcapture follows a capture on a pending input flag, that a forced update loads the correct counter start value, that an output-channel event leaves its capture register alone, that a hardware set beats a same-cycle clear, and that DMA pulses follow command writes. Several behaviours can only be shown by the bench's scenarios: prescaler restart timing, centre-mode turnaround, the interaction of commutation with `ccpc`, and the rule that reserved and zero bits do nothing. The bench's reference model follows the whole port state on every clock during those scenarios.

// File: rtl/tmr_evgen.sv
module tmr_evgen #(
  parameter int CW = 16,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [15:0]       cmd_wdata,
  output logic [15:0]       cmd_rdata,
  input  logic              sts_we,
  input  logic [15:0]       sts_wdata,
  output logic [15:0]       sts_rdata,
  input  logic [7:0]        irq_en,
  input  logic [7:0]        dma_en,
  input  logic              cnt_en,
  input  logic              dir_down,
  input  logic              center,
  input  logic [CW-1:0]     arr,
  input  logic [CW-1:0]     psc,
  input  logic [NCH-1:0]    ch_in,
  input  logic              ccpc,
  input  logic [8:0]        pre_cfg,
  input  logic              moe_set,
  output logic [CW-1:0]     cnt,
  output logic [NCH*CW-1:0] ccr,
  output logic [8:0]        act_cfg,
  output logic              moe,
  output logic              irq,
  output logic [7:0]        dma_req
);
  localparam int OVB = 9;

  logic [7:0]     ev, ef;
  logic [NCH-1:0] ov;
  logic [CW-1:0]  pcnt;
  logic           cdn;

  assign ev        = cmd_we ? cmd_wdata[7:0] : 8'h00;
  assign cmd_rdata = '0;
  assign irq       = |(ef & irq_en);

  always_comb begin
    sts_rdata = '0;
    sts_rdata[7:0] = ef;
    sts_rdata[OVB +: NCH] = ov;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ef      <= '0;
      ov      <= '0;
      moe     <= 1'b0;
      act_cfg <= '0;
      dma_req <= '0;
    end else begin
      ef <= (sts_we ? (ef & sts_wdata[7:0]) : ef) | ev;
      ov <= (sts_we ? (ov & sts_wdata[OVB +: NCH]) : ov) | (ev[NCH:1] & ch_in & ef[NCH:1]);
      if (ev[7])        moe <= 1'b0;
      else if (moe_set) moe <= 1'b1;
      if (ev[5] && ccpc) act_cfg <= pre_cfg;
      dma_req <= ev & dma_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pcnt <= '0;
      cdn  <= 1'b0;
    end else if (ev[0]) begin
      pcnt <= '0;
      cdn  <= 1'b0;
      cnt  <= (dir_down && !center) ? arr : '0;
    end else if (cnt_en) begin
      if (pcnt < psc) begin
        pcnt <= pcnt + 1'b1;
      end else begin
        pcnt <= '0;
        if (center) begin
          if (!cdn) begin
            if (cnt >= arr) begin cnt <= cnt - 1'b1; cdn <= 1'b1; end
            else cnt <= cnt + 1'b1;
          end else begin
            if (cnt == '0) begin cnt <= cnt + 1'b1; cdn <= 1'b0; end
            else cnt <= cnt - 1'b1;
          end
        end else if (dir_down) begin
          cnt <= (cnt == '0) ? arr : cnt - 1'b1;
        end else begin
          cnt <= (cnt >= arr) ? '0 : cnt + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     ccr[i*CW +: CW] <= '0;
      else if (ev[i+1] && ch_in[i])   ccr[i*CW +: CW] <= cnt;
    end
  end
endmodule

module tmr_evgen_chk #(
  parameter int CW = 16,
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_we,
  input logic [15:0]       cmd_wdata,
  input logic              sts_we,
  input logic [15:0]       sts_wdata,
  input logic [15:0]       sts_rdata,
  input logic [7:0]        dma_en,
  input logic              dir_down,
  input logic              center,
  input logic [CW-1:0]     arr,
  input logic [NCH-1:0]    ch_in,
  input logic              moe_set,
  input logic [CW-1:0]     cnt,
  input logic [NCH*CW-1:0] ccr,
  input logic              moe,
  input logic [7:0]        dma_req
);
  a_r3_brake_drops_moe: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[7]) |=> (!moe && sts_rdata[7]));

  a_r7_overcapture: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[1] && ch_in[0] && sts_rdata[1]) |=> sts_rdata[9]);

  a_r8_update_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[0]) |=>
      (cnt == (($past(dir_down) && !$past(center)) ? $past(arr) : '0)));

  a_r6_output_chan_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[2] && !ch_in[1]) |=> $stable(ccr[2*CW-1:CW]));

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[6] && sts_we && !sts_wdata[6]) |=> sts_rdata[6]);

  a_r11_dma_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (dma_req == ($past(cmd_we) ? ($past(cmd_wdata[7:0]) & $past(dma_en)) : 8'h00)));

  a_r3_moe_set: assert property (@(posedge clk) disable iff (!rst_n)
    (moe_set && !(cmd_we && cmd_wdata[7])) |=> moe);
endmodule

bind tmr_evgen tmr_evgen_chk #(.CW(CW), .NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
  .dma_en(dma_en), .dir_down(dir_down), .center(center), .arr(arr),
  .ch_in(ch_in), .moe_set(moe_set), .cnt(cnt), .ccr(ccr), .moe(moe),
  .dma_req(dma_req)
);

// File: tb/tmr_evgen_tb_top.sv
`timescale 1ns/1ps
module tmr_evgen_tb_top;
  logic clk = 0, rst_n = 0;
  logic cmd_we = 0, sts_we = 0, cnt_en = 0, dir_down = 0, center = 0, ccpc = 0, moe_set = 0;
  logic [15:0] cmd_wdata = 0, sts_wdata = 0, arr = 0, psc = 0;
  logic [7:0] irq_en = 0, dma_en = 0;
  logic [3:0] ch_in = 0;
  logic [8:0] pre_cfg = 0;
  logic [15:0] cmd_rdata, sts_rdata, cnt;
  logic [63:0] ccr;
  logic [8:0] act_cfg;
  logic moe, irq;
  logic [7:0] dma_req;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tmr_evgen dut_i (.*);

  // behavioural reference model
  int m_cnt, m_pc, m_cap[4];
  bit m_flag[8], m_ov[4], m_moe, m_dma[8], m_down;
  int m_cfg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pc = 0; m_moe = 0; m_cfg = 0; m_down = 0;
      foreach (m_flag[k]) begin m_flag[k] = 0; m_dma[k] = 0; end
      foreach (m_cap[k]) begin m_cap[k] = 0; m_ov[k] = 0; end
    end else begin
      bit fire[8];
      bit oldf[8];
      int oldc;
      oldc = m_cnt;
      for (int k = 0; k < 8; k++) begin
        fire[k] = cmd_we && cmd_wdata[k];
        oldf[k] = m_flag[k];
        if (sts_we && !sts_wdata[k]) m_flag[k] = 0;
        if (fire[k]) m_flag[k] = 1;
        m_dma[k] = fire[k] && dma_en[k];
      end
      for (int c = 0; c < 4; c++) begin
        if (sts_we && !sts_wdata[9+c]) m_ov[c] = 0;
        if (fire[c+1] && ch_in[c]) begin
          m_cap[c] = oldc;
          if (oldf[c+1]) m_ov[c] = 1;
        end
      end
      if (fire[7]) m_moe = 0; else if (moe_set) m_moe = 1;
      if (fire[5] && ccpc) m_cfg = pre_cfg;
      if (fire[0]) begin
        m_pc = 0; m_down = 0;
        m_cnt = (dir_down && !center) ? arr : 0;
      end else if (cnt_en) begin
        if (m_pc < psc) m_pc++;
        else begin
          m_pc = 0;
          if (center) begin
            if (!m_down && m_cnt >= arr) begin m_down = 1; m_cnt--; end
            else if (m_down && m_cnt == 0) begin m_down = 0; m_cnt++; end
            else if (m_down) m_cnt--;
            else m_cnt++;
          end else if (dir_down) m_cnt = (m_cnt == 0) ? arr : m_cnt - 1;
          else m_cnt = (m_cnt >= arr) ? 0 : m_cnt + 1;
        end
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_sts();
    logic [15:0] s = 0;
    for (int k = 0; k < 8; k++) s[k] = m_flag[k];
    for (int c = 0; c < 4; c++) s[9+c] = m_ov[c];
    return s;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    logic [7:0] md;
    logic [63:0] mc;
    logic [15:0] ms;
    ms = m_sts();
    for (int k = 0; k < 8; k++) md[k] = m_dma[k];
    for (int c = 0; c < 4; c++) mc[c*16 +: 16] = m_cap[c][15:0];
    chk("R12 cnt", cnt, m_cnt[15:0]);
    chk("R7 ccr", ccr, mc);
    chk("R9 sts", sts_rdata, ms);
    chk("R3 moe", moe, m_moe);
    chk("R5 act_cfg", act_cfg, m_cfg[8:0]);
    chk("R11 dma", dma_req, md);
    chk("R10 irq", irq, |(ms[7:0] & irq_en));
    chk("R2 rdata", cmd_rdata, 0);
  end

  task automatic wr(logic [15:0] v);
    @(negedge clk); cmd_we = 1; cmd_wdata = v;
    @(negedge clk); cmd_we = 0; cmd_wdata = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #(5ns * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt", cnt, 0); chk("R1 sts", sts_rdata, 0); chk("R1 ccr", ccr, 0);
    chk("R1 moe", moe, 0); chk("R1 dma", dma_req, 0); chk("R1 cfg", act_cfg, 0);

    arr = 9; psc = 2; cnt_en = 1; irq_en = 8'h41; dma_en = 8'h4F;
    idle(40);                                    // R12 up counting
    wr(16'h0040);                                // R4 trigger
    chk("R4 trig flag", sts_rdata[6], 1);
    chk("R10 irq on trig", irq, 1);
    idle(1);
    chk("R11 dma one cycle", dma_req[6], 0);

    @(negedge clk); moe_set = 1; @(negedge clk); moe_set = 0;
    chk("R3 moe set", moe, 1);
    @(negedge clk); moe_set = 1; cmd_we = 1; cmd_wdata = 16'h0080;
    @(negedge clk); moe_set = 0; cmd_we = 0; cmd_wdata = 0;
    chk("R3 brake priority", moe, 0);
    chk("R3 brake flag", sts_rdata[7], 1);

    pre_cfg = 9'h1A5; ccpc = 0; wr(16'h0020);
    chk("R5 no ccpc", act_cfg, 0);
    ccpc = 1; wr(16'h0020);
    chk("R5 ccpc applies", act_cfg, 9'h1A5);

    ch_in = 4'b1101; idle(7);
    wr(16'h0004);                                // R6 output channel 2
    chk("R6 ccr2 unchanged", ccr[31:16], 0);
    chk("R6 flag2", sts_rdata[2], 1);

    wr(16'h0002); idle(5); wr(16'h0002);         // R7 capture twice
    chk("R7 overcapture", sts_rdata[9], 1);
    wr(16'h0018); idle(4);

    @(negedge clk); sts_we = 1; sts_wdata = 16'h0000; cmd_we = 1; cmd_wdata = 16'hFF40;
    @(negedge clk); sts_we = 0; cmd_we = 0; cmd_wdata = 0;
    chk("R9 hw set wins", sts_rdata, 16'h0040);
    chk("R2 reserved ignored", moe, 0);

    wr(16'hFF00); idle(3);                       // R2 reserved bits only
    chk("R2 no flags", sts_rdata, 16'h0040);
    @(negedge clk); sts_we = 1; sts_wdata = 16'hFFBF;
    @(negedge clk); sts_we = 0;
    chk("R9 write zero clears", sts_rdata, 0);
    chk("R10 irq low", irq, 0);

    idle(4);
    wr(16'h0001);                                // R8 update, up
    chk("R8 up load", cnt, 0);
    idle(2); chk("R8 psc restart hold", cnt, 0);
    idle(1); chk("R8 psc restart step", cnt, 1);

    dir_down = 1; idle(20);                      // R12 down
    wr(16'h0001);
    chk("R8 down load", cnt, 9);
    idle(30);
    center = 1; psc = 0; wr(16'h0001);
    chk("R8 centre load", cnt, 0);
    idle(30);                                    // R12 centre
    dma_en = 8'h00; wr(16'h00FF); idle(1);
    cnt_en = 0; idle(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule